// File: doc/BRIEF.md
# Power-Down Mode Controller

This block sequences the operating mode of a small processor system. It follows two board pins, a standby pin and a reset pin, both active low. It also follows a one-cycle sleep request from the CPU, a standby-select bit, a CPU clock-divide field, two module-stop masks and the interrupt lines. From these it decides which of seven modes the system is in. It drives only enables: the CPU clock enable, one clock enable for each peripheral module, the watchdog clock enable and the oscillator enable. It also reports the current mode and pulses a wake strobe when a low-power mode ends.

Both pins pass through a two-flop synchronizer, so a pin change reaches the mode register on the third rising clock edge after it is applied. The standby pin overrides everything. The reset pin overrides everything except standby. A sleep request has an effect only while the CPU is executing. Each low-power mode accepts its own set of wake-up sources.

Bit 0 of the primary module-stop mask belongs to the 8-bit timer. The watchdog has no stop bit.

Top module: `pwrdn_mode_ctrl`

## Requirements
- R1: `mode` is encoded as 0 reset, 1 high-speed, 2 clock-divided, 3 sleep, 4 all-module-clocks-stop, 5 software standby, 6 hardware standby. While the synchronized standby pin is low, the mode becomes 6 from any mode, on the third edge after the pin falls. When the pin rises again, mode 6 is left for mode 0.
- R2: Outside hardware standby, a low synchronized reset pin forces mode 0 on the third edge after the pin falls. After the pin rises, mode 0 moves to execution on the third edge.
- R3: During execution, `clk_div_sel` equal to 0 gives mode 1 and any nonzero value gives mode 2, one edge after the field changes and without any sleep request.
- R4: A sleep request in mode 1 or 2 with `stby_sel`=0 enters mode 4 when `mstop_ext` is all ones and `mstop_main` is all ones, with bit 0 either 0 or 1. Otherwise it enters mode 3.
- R5: A sleep request in mode 1 or 2 with `stby_sel`=1 enters mode 5.
- R6: In mode 3, any of `nmi`, `irq`, `tmr8_irq`, `wdt_irq` or `misc_irq` wakes the block.
- R7: In mode 4, only `nmi`, `irq`, `wdt_irq`, and `tmr8_irq` while `mstop_main[0]`=0, wake the block. `misc_irq` is ignored.
- R8: In mode 5, only `nmi` and the `irq` lines whose `irq_wake_en` bit is 1 wake the block.
- R9: A wake returns the block to execution (mode 1 or 2, chosen by `clk_div_sel`) on the next edge. In that same cycle `wake_exc` is 1, and it is 1 for exactly that one cycle.
- R10: `cpu_clk_en` is 1 only in modes 1 and 2. `osc_en` is 0 only in modes 5 and 6.
- R11: In modes 1, 2 and 3, `mod_clk_en_main`/`mod_clk_en_ext` are the inverted stop masks and `wdt_clk_en` is 1. In mode 4, only `mod_clk_en_main[0]` may be 1 (equal to the inverse of `mstop_main[0]`) and `wdt_clk_en` is 1. In modes 0, 5 and 6, all module enables and `wdt_clk_en` are 0.
- R12: A sleep request in modes 0, 3, 4, 5 or 6 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset of the block's flops, active low |
| stby_pin_n | input | 1 | Standby pin, active low, asynchronous |
| res_pin_n | input | 1 | Reset pin, active low, asynchronous |
| sleep_req | input | 1 | One-cycle sleep request from the CPU |
| stby_sel | input | 1 | 1 makes a sleep request enter software standby |
| clk_div_sel | input | 3 | CPU clock-divide field, 0 means full speed |
| mstop_main | input | 16 | Primary module-stop mask, bit 0 is the 8-bit timer |
| mstop_ext | input | 16 | Extension module-stop mask |
| nmi | input | 1 | Non-maskable interrupt |
| irq | input | 16 | External interrupt lines |
| irq_wake_en | input | 16 | Per-line wake enable in software standby |
| tmr8_irq | input | 1 | 8-bit timer interrupt |
| wdt_irq | input | 1 | Watchdog interrupt |
| misc_irq | input | 1 | Any other internal interrupt |
| mode | output | 3 | Current mode code |
| cpu_clk_en | output | 1 | CPU clock enable |
| mod_clk_en_main | output | 16 | Module clock enables for the primary mask |
| mod_clk_en_ext | output | 16 | Module clock enables for the extension mask |
| wdt_clk_en | output | 1 | Watchdog clock enable |
| osc_en | output | 1 | Oscillator enable |
| wake_exc | output | 1 | One-cycle wake-exception strobe |

## Verification
The mode register is the only state besides the synchronizers, and every output is decoded from it. A wrong state therefore shows at once on `mode`, and in the same cycle on the clock and oscillator enables. A lost or stuck wake strobe shows one edge after the wake. A missed pin override appears as the wrong `mode` on the third edge after the pin moves, which is why every check of a pin scenario samples exactly at that edge. Wake-source filtering is checked by holding each ignored source high for several cycles and watching `mode` stay put, then applying an accepted source and seeing the one-edge return.

// File: rtl/pdm_pkg.sv
package pdm_pkg;

    typedef enum logic [2:0] {
        MD_RESET   = 3'd0,
        MD_HIGH    = 3'd1,
        MD_DIV     = 3'd2,
        MD_SLEEP   = 3'd3,
        MD_ALLSTOP = 3'd4,
        MD_SWSTBY  = 3'd5,
        MD_HWSTBY  = 3'd6
    } pdm_mode_e;

    typedef struct packed {
        pdm_mode_e mode;
        logic      wake;
    } pdm_state_t;

    function automatic logic pdm_is_exec(input pdm_mode_e m);
        return (m == MD_HIGH) || (m == MD_DIV);
    endfunction

endpackage

// File: rtl/pdm_pin_sync.sv
module pdm_pin_sync #(
    parameter int          NUM_PINS = 2,
    parameter int          STAGES   = 2,
    parameter logic [NUM_PINS-1:0] RST_VAL = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_async,
    output logic [NUM_PINS-1:0] pin_sync
);

    logic [NUM_PINS-1:0][STAGES-1:0] chain_d, chain_q;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        always_comb begin
            chain_d[p] = {chain_q[p][STAGES-2:0], pin_async[p]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q[p] <= {STAGES{RST_VAL[p]}};
            end else begin
                chain_q[p] <= chain_d[p];
            end
        end

        assign pin_sync[p] = chain_q[p][STAGES-1];
    end

endmodule

// File: rtl/pdm_wake_eval.sv
module pdm_wake_eval
    import pdm_pkg::*;
#(
    parameter int NUM_IRQ = 16
) (
    input  pdm_mode_e          mode,
    input  logic               nmi,
    input  logic [NUM_IRQ-1:0] irq,
    input  logic [NUM_IRQ-1:0] irq_wake_en,
    input  logic               tmr8_irq,
    input  logic               tmr8_stopped,
    input  logic               wdt_irq,
    input  logic               misc_irq,
    output logic               wake
);

    logic any_irq;
    logic en_irq;

    always_comb begin
        any_irq = |irq;
        en_irq  = |(irq & irq_wake_en);
        unique case (mode)
            MD_SLEEP:   wake = nmi | any_irq | tmr8_irq | wdt_irq | misc_irq;
            MD_ALLSTOP: wake = nmi | any_irq | wdt_irq | (tmr8_irq & ~tmr8_stopped);
            MD_SWSTBY:  wake = nmi | en_irq;
            default:    wake = 1'b0;
        endcase
    end

endmodule

// File: rtl/pdm_clk_gate.sv
module pdm_clk_gate
    import pdm_pkg::*;
#(
    parameter int NUM_MAIN = 16,
    parameter int NUM_EXT  = 16,
    parameter int TMR8_BIT = 0
) (
    input  pdm_mode_e           mode,
    input  logic [NUM_MAIN-1:0] mstop_main,
    input  logic [NUM_EXT-1:0]  mstop_ext,
    output logic                cpu_clk_en,
    output logic                osc_en,
    output logic                wdt_clk_en,
    output logic [NUM_MAIN-1:0] mod_en_main,
    output logic [NUM_EXT-1:0]  mod_en_ext
);

    logic run_mods;

    always_comb begin
        run_mods   = pdm_is_exec(mode) || (mode == MD_SLEEP);
        cpu_clk_en = pdm_is_exec(mode);
        osc_en     = !((mode == MD_SWSTBY) || (mode == MD_HWSTBY));
        wdt_clk_en = run_mods || (mode == MD_ALLSTOP);
        mod_en_ext = run_mods ? ~mstop_ext : '0;
    end

    for (genvar b = 0; b < NUM_MAIN; b++) begin : g_main
        if (b == TMR8_BIT) begin : g_tmr
            assign mod_en_main[b] = (run_mods || (mode == MD_ALLSTOP)) && !mstop_main[b];
        end else begin : g_other
            assign mod_en_main[b] = run_mods && !mstop_main[b];
        end
    end

endmodule

// File: rtl/pwrdn_mode_ctrl.sv
module pwrdn_mode_ctrl
    import pdm_pkg::*;
#(
    parameter int NUM_MAIN = 16,
    parameter int NUM_EXT  = 16,
    parameter int NUM_IRQ  = 16,
    parameter int CDIV_W   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stby_pin_n,
    input  logic                res_pin_n,
    input  logic                sleep_req,
    input  logic                stby_sel,
    input  logic [CDIV_W-1:0]   clk_div_sel,
    input  logic [NUM_MAIN-1:0] mstop_main,
    input  logic [NUM_EXT-1:0]  mstop_ext,
    input  logic                nmi,
    input  logic [NUM_IRQ-1:0]  irq,
    input  logic [NUM_IRQ-1:0]  irq_wake_en,
    input  logic                tmr8_irq,
    input  logic                wdt_irq,
    input  logic                misc_irq,
    output logic [2:0]          mode,
    output logic                cpu_clk_en,
    output logic [NUM_MAIN-1:0] mod_clk_en_main,
    output logic [NUM_EXT-1:0]  mod_clk_en_ext,
    output logic                wdt_clk_en,
    output logic                osc_en,
    output logic                wake_exc
);

    localparam int SYNC_STAGES = 2;
    localparam int TMR8_BIT    = 0;

    // index 1 = standby pin (idle high), index 0 = reset pin (asserted at reset)
    logic [1:0] pins_s;
    logic       stby_s;
    logic       res_s;

    pdm_pin_sync #(
        .NUM_PINS (2),
        .STAGES   (SYNC_STAGES),
        .RST_VAL  (2'b10)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async ({stby_pin_n, res_pin_n}),
        .pin_sync  (pins_s)
    );

    assign stby_s = pins_s[1];
    assign res_s  = pins_s[0];

    pdm_state_t cur_q, nxt_d;
    logic       wake_hit;
    logic       allstop_ok;
    pdm_mode_e  exec_mode;

    pdm_wake_eval #(
        .NUM_IRQ (NUM_IRQ)
    ) u_wake (
        .mode         (cur_q.mode),
        .nmi          (nmi),
        .irq          (irq),
        .irq_wake_en  (irq_wake_en),
        .tmr8_irq     (tmr8_irq),
        .tmr8_stopped (mstop_main[TMR8_BIT]),
        .wdt_irq      (wdt_irq),
        .misc_irq     (misc_irq),
        .wake         (wake_hit)
    );

    always_comb begin
        exec_mode  = (clk_div_sel == '0) ? MD_HIGH : MD_DIV;
        allstop_ok = (&mstop_ext) && (&mstop_main[NUM_MAIN-1:1]);
        nxt_d      = cur_q;
        nxt_d.wake = 1'b0;
        if (!stby_s) begin
            nxt_d.mode = MD_HWSTBY;
        end else if (cur_q.mode == MD_HWSTBY) begin
            nxt_d.mode = MD_RESET;
        end else if (!res_s) begin
            nxt_d.mode = MD_RESET;
        end else begin
            unique case (cur_q.mode)
                MD_RESET: nxt_d.mode = exec_mode;
                MD_HIGH, MD_DIV: begin
                    if (sleep_req) begin
                        if (stby_sel)        nxt_d.mode = MD_SWSTBY;
                        else if (allstop_ok) nxt_d.mode = MD_ALLSTOP;
                        else                 nxt_d.mode = MD_SLEEP;
                    end else begin
                        nxt_d.mode = exec_mode;
                    end
                end
                MD_SLEEP, MD_ALLSTOP, MD_SWSTBY: begin
                    if (wake_hit) begin
                        nxt_d.mode = exec_mode;
                        nxt_d.wake = 1'b1;
                    end
                end
                default: nxt_d.mode = MD_RESET;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.mode <= MD_RESET;
            cur_q.wake <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    pdm_clk_gate #(
        .NUM_MAIN (NUM_MAIN),
        .NUM_EXT  (NUM_EXT),
        .TMR8_BIT (TMR8_BIT)
    ) u_gate (
        .mode        (cur_q.mode),
        .mstop_main  (mstop_main),
        .mstop_ext   (mstop_ext),
        .cpu_clk_en  (cpu_clk_en),
        .osc_en      (osc_en),
        .wdt_clk_en  (wdt_clk_en),
        .mod_en_main (mod_clk_en_main),
        .mod_en_ext  (mod_clk_en_ext)
    );

    assign mode     = cur_q.mode;
    assign wake_exc = cur_q.wake;

    AST_STBY_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        !stby_s |=> cur_q.mode == MD_HWSTBY); // R1
    AST_HWSTBY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (stby_s && cur_q.mode == MD_HWSTBY) |=> cur_q.mode == MD_RESET); // R1
    AST_RES_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        (stby_s && !res_s && cur_q.mode != MD_HWSTBY) |=> cur_q.mode == MD_RESET); // R2
    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_exc |=> !wake_exc); // R9
    AST_WAKE_TO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        wake_exc |-> (mode == 3'd1 || mode == 3'd2)); // R9
    AST_SWSTBY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (stby_s && res_s && cur_q.mode == MD_SWSTBY && !nmi && !(|(irq & irq_wake_en)))
        |=> cur_q.mode == MD_SWSTBY); // R8
    AST_OSC_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> !cpu_clk_en); // R10

endmodule

// File: tb/tb_pwrdn_mode_ctrl.sv
module tb_pwrdn_mode_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stby_pin_n = 1'b1;
    logic        res_pin_n = 1'b1;
    logic        sleep_req = 1'b0;
    logic        stby_sel = 1'b0;
    logic [2:0]  clk_div_sel = '0;
    logic [15:0] mstop_main = '0;
    logic [15:0] mstop_ext = '0;
    logic        nmi = 1'b0;
    logic [15:0] irq = '0;
    logic [15:0] irq_wake_en = '0;
    logic        tmr8_irq = 1'b0;
    logic        wdt_irq = 1'b0;
    logic        misc_irq = 1'b0;
    logic [2:0]  mode;
    logic        cpu_clk_en;
    logic [15:0] mod_clk_en_main;
    logic [15:0] mod_clk_en_ext;
    logic        wdt_clk_en;
    logic        osc_en;
    logic        wake_exc;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    pwrdn_mode_ctrl dut (
        .clk(clk), .rst_n(rst_n), .stby_pin_n(stby_pin_n), .res_pin_n(res_pin_n),
        .sleep_req(sleep_req), .stby_sel(stby_sel), .clk_div_sel(clk_div_sel),
        .mstop_main(mstop_main), .mstop_ext(mstop_ext), .nmi(nmi), .irq(irq),
        .irq_wake_en(irq_wake_en), .tmr8_irq(tmr8_irq), .wdt_irq(wdt_irq),
        .misc_irq(misc_irq), .mode(mode), .cpu_clk_en(cpu_clk_en),
        .mod_clk_en_main(mod_clk_en_main), .mod_clk_en_ext(mod_clk_en_ext),
        .wdt_clk_en(wdt_clk_en), .osc_en(osc_en), .wake_exc(wake_exc)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic sleep_pulse();
        sleep_req = 1'b1;
        tick(1);
        sleep_req = 1'b0;
    endtask

    task automatic t_reset();
        tick(2);
        rst_n = 1'b1;
        #1;
        check("R2", "mode after block reset", mode, 0);
        check("R10", "cpu_clk_en in reset", cpu_clk_en, 0);
        check("R11", "wdt_clk_en in reset", wdt_clk_en, 0);
        tick(2);
        check("R2", "still reset before sync", mode, 0);
        tick(1);
        check("R2", "exec after reset pin high", mode, 1);
        check("R10", "cpu_clk_en in exec", cpu_clk_en, 1);
    endtask

    task automatic t_cdiv();
        mstop_main = 16'h0F0F;
        mstop_ext  = 16'h8001;
        tick(1);
        check("R11", "main enables in exec", mod_clk_en_main, 16'hF0F0);
        check("R11", "ext enables in exec", mod_clk_en_ext, 16'h7FFE);
        clk_div_sel = 3'd4;
        tick(1);
        check("R3", "divided mode", mode, 2);
        clk_div_sel = 3'd0;
        tick(1);
        check("R3", "back to high speed", mode, 1);
    endtask

    task automatic t_sleep();
        stby_sel   = 1'b0;
        mstop_main = 16'hFFFD;
        mstop_ext  = 16'hFFFF;
        sleep_pulse();
        check("R4", "sleep when mask not all ones", mode, 3);
        check("R10", "cpu off in sleep", cpu_clk_en, 0);
        check("R10", "osc on in sleep", osc_en, 1);
        check("R11", "modules run in sleep", mod_clk_en_main, 16'h0002);
        stby_sel = 1'b1;
        sleep_pulse();
        check("R12", "sleep request ignored in sleep", mode, 3);
        stby_sel = 1'b0;
        tick(3);
        check("R6", "no wake without interrupt", mode, 3);
        misc_irq = 1'b1;
        tick(1);
        misc_irq = 1'b0;
        check("R6", "misc irq wakes sleep", mode, 1);
        check("R9", "wake strobe high", wake_exc, 1);
        tick(1);
        check("R9", "wake strobe one cycle", wake_exc, 0);
    endtask

    task automatic t_allstop();
        mstop_main = 16'hFFFF;
        mstop_ext  = 16'hFFFF;
        sleep_pulse();
        check("R4", "all-stop with full masks", mode, 4);
        check("R11", "timer off in all-stop", mod_clk_en_main, 16'h0000);
        check("R11", "wdt on in all-stop", wdt_clk_en, 1);
        misc_irq = 1'b1;
        tmr8_irq = 1'b1;
        tick(3);
        check("R7", "misc and stopped timer ignored", mode, 4);
        misc_irq = 1'b0;
        tmr8_irq = 1'b0;
        clk_div_sel = 3'd2;
        wdt_irq = 1'b1;
        tick(1);
        wdt_irq = 1'b0;
        check("R9", "wdt wake to divided mode", mode, 2);
        check("R7", "wake strobe after wdt", wake_exc, 1);
        clk_div_sel = 3'd0;
        mstop_main  = 16'hFFFE;
        tick(1);
        sleep_pulse();
        check("R4", "all-stop with bit0 clear", mode, 4);
        check("R11", "timer clock in all-stop", mod_clk_en_main, 16'h0001);
        tmr8_irq = 1'b1;
        tick(1);
        tmr8_irq = 1'b0;
        check("R7", "running timer wakes", mode, 1);
    endtask

    task automatic t_swstby();
        stby_sel    = 1'b1;
        mstop_main  = 16'h0000;
        mstop_ext   = 16'h0000;
        irq_wake_en = 16'hFFF7;
        sleep_pulse();
        check("R5", "software standby", mode, 5);
        check("R10", "osc off in sw standby", osc_en, 0);
        check("R11", "modules off in sw standby", mod_clk_en_main, 16'h0000);
        irq[3]   = 1'b1;
        wdt_irq  = 1'b1;
        misc_irq = 1'b1;
        tick(3);
        check("R8", "disabled irq and wdt ignored", mode, 5);
        wdt_irq  = 1'b0;
        misc_irq = 1'b0;
        irq_wake_en[3] = 1'b1;
        tick(1);
        irq[3] = 1'b0;
        check("R8", "enabled irq wakes", mode, 1);
        sleep_pulse();
        nmi = 1'b1;
        tick(1);
        nmi = 1'b0;
        check("R8", "nmi wakes sw standby", mode, 1);
    endtask

    task automatic t_pins();
        stby_sel = 1'b1;
        sleep_pulse();
        res_pin_n = 1'b0;
        tick(2);
        check("R2", "reset not yet synchronized", mode, 5);
        tick(1);
        check("R2", "reset from sw standby", mode, 0);
        sleep_pulse();
        check("R12", "sleep ignored in reset", mode, 0);
        stby_pin_n = 1'b0;
        tick(3);
        check("R1", "hw standby beats reset", mode, 6);
        check("R10", "osc off in hw standby", osc_en, 0);
        sleep_pulse();
        check("R12", "sleep ignored in hw standby", mode, 6);
        stby_pin_n = 1'b1;
        res_pin_n  = 1'b1;
        tick(3);
        check("R1", "hw standby exits to reset", mode, 0);
        tick(1);
        check("R2", "exec after standby exit", mode, 1);
    endtask

    initial begin
        t_reset();
        t_cdiv();
        t_sleep();
        t_allstop();
        t_swstby();
        t_pins();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule